// File: doc/BRIEF.md
# Word-Driven SPI Master Sequencer

This block is an SPI master that runs one transfer at a time from a stream of 32-bit command words. Each word has up to 16 bits of payload. It also has its own controls: which of four chip-select lines to drive low, how many bits to shift, whether the word closes a transfer, whether it closes a frame, and whether the bits clocked in while it shifts are kept. Command words arrive on a valid/ready channel that a transmit FIFO would feed. Received words leave on a second valid/ready channel toward a receive FIFO.

The serial side runs in SPI mode 0. SCK idles low and MISO is sampled on the rising edge. MOSI changes after the falling edge, most significant bit first. One SCK half-period lasts `HALF_DIV` system clocks. Selects stay low from one word to the next unless a word closes the transfer, so longer transfers are built from several words. After a word that closes a transfer or a frame, a gap is inserted before the next word. The gap length comes from two configuration inputs counted in SCK half-periods, and the longer of the two applies when both are due.

Top module: `spi_word_seq`

## Requirements
- R1: Bits 15:0 of a command word carry the payload. Bits 27:24 carry a length code, and the word shifts code+1 bits. The payload bits shifted are the lowest code+1 bits of 15:0, sent MSB first on MOSI. MOSI is stable while SCK is high.
- R2: Length codes 0, 1 and 2 are reserved and shift 4 bits, the same as code 3.
- R3: Bits 19:16 drive ssel_n[3:0] one for one, so a 0 bit pulls that line low. ssel_n takes the word's value when the word is accepted and holds it through every SCK edge of the word.
- R4: Bit 20 closes the transfer. When that word's last falling SCK edge occurs, ssel_n goes to 4'hF. At least xfer_gap SCK half-periods pass before the next rising SCK edge. With no further word, the block idles with ssel_n at 4'hF and SCK low.
- R5: When bit 20 is clear, ssel_n keeps the word's value after its last bit. When bit 21 is also clear, the next waiting word starts with no inserted gap: its first rising edge comes within one half-period plus two clocks of the previous falling edge.
- R6: Bit 21 closes a frame. At least frame_gap SCK half-periods pass before the next rising SCK edge. A frame_gap of zero inserts no gap.
- R7: When bit 22 is set, no received word is presented on rx_valid for that command word.
- R8: MISO is sampled on each rising SCK edge, MSB first. The received word on rx_data is right-aligned, and its bits above the word length are zero.
- R9: A word with bit 22 clear does not begin shifting while an earlier received word is still waiting on rx_valid. A word with bit 22 set shifts regardless. rx_valid and rx_data hold steady while rx_ready is low.
- R10: After reset, ssel_n is 4'hF, SCK is low, rx_valid is low and cmd_ready is high. An all-zero command word pulls all four selects low and shifts 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word taken this cycle when valid |
| cmd_word | input | 32 | Command word: payload, selects, length and flags |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word, right-aligned |
| xfer_gap | input | GAP_W | Half-periods of idle after a transfer-closing word |
| frame_gap | input | GAP_W | Half-periods of idle after a frame-closing word |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 4 | Active-low slave selects |

## Verification
The bench builds the block with `HALF_DIV` = 2 and `GAP_W` = 6. A two-clock half-period keeps each word short, so sixteen-bit words, reserved length codes and all the gap combinations fit in a few thousand cycles. This setting also keeps the timing distinct: the divider count is separate from the one-cycle accept and hold steps, so an off-by-one in the gap or divider logic shows up as a measured interval outside its window. With a 6-bit gap field, transfer and frame delays of 3 and 5 half-periods, and a frame delay of zero, can be compared inside a single run.

// File: rtl/spi_word_seq.sv
module spi_word_seq #(
  parameter int HALF_DIV = 2,
  parameter int GAP_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_word,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [15:0]      rx_data,
  input  logic [GAP_W-1:0] xfer_gap,
  input  logic [GAP_W-1:0] frame_gap,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       ssel_n
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_SHIFT, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_cnt;
  logic [15:0]      tx_sh, rx_sh;
  logic [4:0]       bits_left;
  logic             ign_q, eot_q, eof_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             unused_bits;

  wire [3:0]       len_code = cmd_word[27:24];
  wire [4:0]       n_bits   = (len_code < 4'd3) ? 5'd4 : {1'b0, len_code} + 5'd1;
  wire             tick     = div_cnt == DIV_LAST;
  wire [GAP_W-1:0] eot_gap  = eot_q ? xfer_gap : '0;
  wire [GAP_W-1:0] eof_gap  = eof_q ? frame_gap : '0;
  wire [GAP_W-1:0] post_gap = (eot_gap > eof_gap) ? eot_gap : eof_gap;

  assign cmd_ready   = st == S_IDLE;
  assign mosi        = tx_sh[15];
  assign unused_bits = ^{cmd_word[31:28], cmd_word[23]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div_cnt   <= '0;
      sck       <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
      ign_q     <= 1'b0;
      eot_q     <= 1'b0;
      eof_q     <= 1'b0;
      ssel_n    <= 4'hF;
      gap_cnt   <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          tx_sh     <= cmd_word[15:0] << (5'd16 - n_bits);
          rx_sh     <= '0;
          bits_left <= n_bits;
          ign_q     <= cmd_word[22];
          eof_q     <= cmd_word[21];
          eot_q     <= cmd_word[20];
          ssel_n    <= cmd_word[19:16];
          st        <= S_HOLD;
        end
        S_HOLD: if (ign_q || !rx_valid) begin
          st      <= S_SHIFT;
          div_cnt <= '0;
        end
        S_SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!sck) begin
              sck   <= 1'b1;
              rx_sh <= {rx_sh[14:0], miso};
            end else begin
              sck <= 1'b0;
              if (bits_left == 5'd1) begin
                if (!ign_q) begin
                  rx_valid <= 1'b1;
                  rx_data  <= rx_sh;
                end
                if (eot_q) ssel_n <= 4'hF;
                gap_cnt <= post_gap;
                div_cnt <= '0;
                st      <= (post_gap == '0) ? S_IDLE : S_GAP;
              end else begin
                tx_sh     <= {tx_sh[14:0], 1'b0};
                bits_left <= bits_left - 5'd1;
              end
            end
          end
        end
        S_GAP: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            gap_cnt <= gap_cnt - 1'b1;
            if (gap_cnt == GAP_W'(1)) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R1
  AST_SEL_STEADY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st == S_SHIFT)) |-> $stable(ssel_n)); // R3
  AST_GAP_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && eot_q) |-> ssel_n == 4'hF); // R4
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && rx_valid && !ign_q) |=> (st == S_HOLD && !sck)); // R9
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
  AST_SCK_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SHIFT) |-> !sck); // R4

endmodule

// File: tb/spi_word_seq_tb_top.sv
`timescale 1ns/1ps
module spi_word_seq_tb_top;
  localparam int H  = 2;
  localparam int GW = 6;
  localparam logic [31:0] PAT = 32'hC3A5_96E1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rx_ready = 1, miso;
  logic [31:0] cmd_word = '0;
  logic [GW-1:0] xfer_gap = 6'd3, frame_gap = 6'd5;
  logic cmd_ready, rx_valid, sck, mosi;
  logic [15:0] rx_data;
  logic [3:0] ssel_n;

  always #2 clk = ~clk;

  spi_word_seq #(.HALF_DIV(H), .GAP_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xfer_gap(xfer_gap), .frame_gap(frame_gap), .sck(sck), .mosi(mosi),
    .miso(miso), .ssel_n(ssel_n));

  typedef struct {
    logic [15:0] tx;
    int          n;
    logic [3:0]  sel;
    bit          eot;
    int          glo;
    int          ghi;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] rxq[$];
  int checks = 0, fails = 0;
  int rcnt = 0, rises = 0, cum = 0, cyc = 0, last_fall = 0;
  bit prev_eot = 0, prev_eof = 0, done = 0;

  assign miso = PAT[31 - (rcnt % 32)];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [3:0] sel, input int code, input logic [15:0] data,
                      input bit eot, input bit eof, input bit ign, input bit chk_gap);
    exp_t e;
    int g;
    logic [16:0] m;
    logic [15:0] r;
    e.n   = (code < 3) ? 4 : code + 1;
    m     = (17'd1 << e.n) - 17'd1;
    e.tx  = data & m[15:0];
    e.sel = sel;
    e.eot = eot;
    g = 0;
    if (prev_eot) g = xfer_gap;
    if (prev_eof && frame_gap > g) g = frame_gap;
    e.glo = chk_gap ? g * H + H : -1;
    e.ghi = g * H + H + 2;
    r = '0;
    for (int i = 0; i < e.n; i++) r = {r[14:0], PAT[31 - ((cum + i) % 32)]};
    cum += e.n;
    exp_q.push_back(e);
    if (!ign) rxq.push_back(r);
    prev_eot = eot;
    prev_eof = eof;
    @(negedge clk);
    cmd_valid = 1;
    cmd_word  = {4'd0, 4'(code), 1'b0, ign, eof, eot, sel, data};
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // monitor: serial side and received words
  initial begin
    exp_t cur;
    int bit_i = 0;
    bit sel_ok = 1, sck_p = 0;
    logic [15:0] got = '0;
    cur = '{tx: 0, n: 0, sel: 0, eot: 0, glo: -1, ghi: 0};
    forever begin
      @(negedge clk);
      cyc++;
      if (sck && !sck_p) begin
        if (bit_i == 0) begin
          if (exp_q.size() == 0) chk(0, "R1 unexpected word", 0, 0);
          else cur = exp_q.pop_front();
          if (cur.glo >= 0)
            chk((cyc - last_fall) >= cur.glo && (cyc - last_fall) <= cur.ghi,
                "R4/R5/R6 gap cycles", cyc - last_fall, cur.glo);
          sel_ok = 1;
        end
        got = {got[14:0], mosi};
        if (ssel_n != cur.sel) sel_ok = 0;
        bit_i++;
        rises++;
      end
      if (!sck && sck_p) begin
        last_fall = cyc;
        rcnt++;
        if (bit_i == cur.n) begin
          chk(got == cur.tx, "R1/R2 mosi word", got, cur.tx);
          chk(sel_ok, "R3 select held over word", ssel_n, cur.sel);
          chk(ssel_n == (cur.eot ? 4'hF : cur.sel), "R4/R5 select after word",
              ssel_n, cur.eot ? 4'hF : cur.sel);
          bit_i = 0;
          got = '0;
        end
      end
      if (rx_valid && rx_ready) begin
        if (rxq.size() == 0) chk(0, "R7 unexpected rx word", rx_data, 0);
        else begin
          logic [15:0] x;
          x = rxq.pop_front();
          chk(rx_data == x, "R8 rx word", rx_data, x);
        end
      end
      sck_p = sck;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ssel_n == 4'hF, "R10 reset ssel_n", ssel_n, 4'hF);
    chk(sck == 0, "R10 reset sck", sck, 0);
    chk(rx_valid == 0, "R10 reset rx_valid", rx_valid, 0);
    chk(cmd_ready == 1, "R10 reset cmd_ready", cmd_ready, 1);

    send(4'h0, 0, 16'h0000, 0, 0, 0, 0);     // R10 all-zero word
    send(4'hE, 15, 16'hA5C3, 1, 0, 0, 1);    // R5 no gap after
    send(4'hD, 7, 16'h005A, 0, 1, 0, 1);     // R4 transfer gap
    send(4'hD, 2, 16'h0009, 1, 1, 0, 1);     // R2 reserved, R6 frame gap
    send(4'hB, 11, 16'h0ABC, 1, 0, 1, 1);    // R7 ignored, max of gaps
    send(4'h7, 4, 16'h0015, 0, 0, 0, 1);
    send(4'h7, 9, 16'h02D3, 1, 0, 0, 1);     // R5 selects carried over
    @(negedge clk);
    cmd_valid = 0;
    repeat (100) @(negedge clk);
    chk(ssel_n == 4'hF, "R4 idle ssel_n", ssel_n, 4'hF);
    chk(sck == 0, "R4 idle sck", sck, 0);

    frame_gap = 6'd0;
    send(4'h3, 5, 16'h002A, 0, 1, 0, 0);
    send(4'h3, 5, 16'h0015, 1, 0, 0, 1);     // R6 zero frame gap
    @(negedge clk);
    cmd_valid = 0;
    repeat (100) @(negedge clk);

    @(posedge clk); #1 rx_ready = 0;
    send(4'hE, 7, 16'h00C7, 1, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 0;
    while (!rx_valid) @(negedge clk);
    r0 = rises;
    send(4'hE, 7, 16'h0033, 1, 0, 1, 0);     // R9 ignored word proceeds
    @(negedge clk);
    cmd_valid = 0;
    repeat (80) @(negedge clk);
    chk(rises == r0 + 8, "R9 ignored word shifted", rises, r0 + 8);
    chk(rx_valid == 1, "R9 rx word still waiting", rx_valid, 1);
    r0 = rises;
    send(4'hE, 15, 16'h1234, 1, 0, 0, 0);    // R9 must stall
    @(negedge clk);
    cmd_valid = 0;
    repeat (40) @(negedge clk);
    chk(rises == r0, "R9 no start while rx full", rises, r0);
    @(posedge clk); #1 rx_ready = 1;
    repeat (150) @(negedge clk);
    chk(rises == r0 + 16, "R9 start after rx drained", rises, r0 + 16);
    chk(exp_q.size() == 0, "R1 all words shifted", exp_q.size(), 0);
    chk(rxq.size() == 0, "R7 all rx words seen", rxq.size(), 0);
    done = 1;
    report();
  end
endmodule